// File: doc/BRIEF.md
# Workgroup Barrier Slot Manager

This block owns a small, fixed pool of barrier slots that let the wavefronts of one workgroup meet at a common point. Dispatch logic requests a slot together with the number of wavefronts that will take part. It receives the lowest free slot number in the same cycle. Each participating wavefront then reports arrival on that slot. When the last expected arrival lands, the block pulses a per-slot release line for one cycle. It also clears the arrival tally, so the next barrier instance on the same slot starts from zero.

A wavefront that terminates early is removed from its slot's participant count. If every remaining participant is already waiting, that removal alone completes the barrier. When the workgroup ends, a free command clears both counts and hands the slot back to the pool. Resetting a completed instance only clears the arrival tally, while freeing also returns the slot; the two are separate operations.

Illegal commands are rejected and reported on a one-cycle error pulse: an unknown or invalid slot, a slot that is not allocated, an arrival beyond the participant count, or a removal from an empty count. The arrive, exit and free ports can each carry one command per cycle. Commands aimed at different slots are handled independently. Allocation attempts made while the pool is empty are counted.

Top module: `wg_barrier_pool`

## Requirements
- R1: After reset no slot is busy, no release or error pulse is raised, the blocked-attempt counter is zero and `noneFree` is low.
- R2: An allocation request grants the lowest-numbered non-busy slot combinationally in the same cycle (`allocGrant`, `allocId`). That slot shows busy from the next cycle, with its participant count set to `allocCount` and its arrival count at zero.
- R3: When every slot is busy, `noneFree` is high and a request is not granted. Each such refused request adds one to `blockedCount`, which saturates at all ones.
- R4: An accepted arrival adds one to the slot's arrival count. When the arrival count reaches a non-zero participant count, `releasePulse[slot]` is high for exactly the cycle after that arrival, and the arrival count restarts at zero with the participant count kept.
- R5: An arrival on a slot whose arrival count already equals its participant count (including a participant count of zero) is rejected: no count changes and `errPulse` is high in the next cycle.
- R6: An exit command lowers the slot's participant count by one. If the remaining arrivals are then all in and the count is non-zero, the slot releases as in R4. An exit on a participant count of zero is rejected and raises `errPulse`.
- R7: An exit and an arrival on the same slot in one cycle are applied exit first. The arrival is then judged against the lowered participant count, so it may be rejected, raising `errPulse`, while the exit still releases the slot.
- R8: A free command on a busy slot clears both counts and makes the slot non-busy from the next cycle, allocatable again. Free, arrive or exit on a non-busy slot raises `errPulse` and changes nothing.
- R9: A slot ID field is `$clog2(NUM_SLOTS+1)` bits wide. The all-ones value means invalid, and any value of `NUM_SLOTS` or above, all-ones included, is rejected with `errPulse` and no state change.
- R10: Commands on the arrive, exit and free ports that target different slots in one cycle all take effect, and several slots may release in the same cycle.
- R11: A free and an arrive or exit on the same slot in one cycle: the free takes effect, and the arrive or exit is rejected with `errPulse` and no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request a free slot |
| allocCount | input | CNT_W | Participant count for the slot being allocated |
| allocGrant | output | 1 | Request granted this cycle |
| allocId | output | ID_W | Granted slot number |
| noneFree | output | 1 | Every slot is busy |
| arriveVld | input | 1 | Arrival command valid |
| arriveId | input | ID_W | Slot of the arrival |
| exitVld | input | 1 | Early-exit command valid |
| exitId | input | ID_W | Slot of the exiting wavefront |
| freeVld | input | 1 | Workgroup-done command valid |
| freeId | input | ID_W | Slot to return to the pool |
| slotBusy | output | NUM_SLOTS | Per-slot allocated flag |
| releasePulse | output | NUM_SLOTS | Per-slot one-cycle barrier release |
| errPulse | output | 1 | One-cycle flag for a rejected command |
| blockedCount | output | BLK_W | Saturating count of refused allocations |

## Verification
The bench builds the block with four slots, a 3-bit participant count and a 4-bit blocked counter. With four slots the pool fills after four grants, so refused allocations and lowest-slot reuse after a free are quick to reach. The 3-bit ID field leaves the values 4 to 6 as out-of-range IDs and 7 as the invalid marker. Twenty refused requests are enough to drive the 4-bit counter into saturation.

// File: rtl/wgbar_pkg.sv
package wgbar_pkg;
  // Per-slot strobes from the command decoder to the slot datapath
  typedef struct packed {
    logic take;    // allocate this slot
    logic drop;    // return this slot to the pool
    logic leave;   // one participant exits
    logic arrive;  // one participant arrives
  } slotCmd_t;
endpackage

// File: rtl/wgbar_ctrl.sv
module wgbar_ctrl
  import wgbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 3,
  parameter int BLK_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          allocReq,
  input  logic                          arriveVld,
  input  logic [ID_W-1:0]               arriveId,
  input  logic                          exitVld,
  input  logic [ID_W-1:0]               exitId,
  input  logic                          freeVld,
  input  logic [ID_W-1:0]               freeId,
  input  logic [NUM_SLOTS-1:0]          slotBusy,
  output slotCmd_t [NUM_SLOTS-1:0]      cmd,
  output logic                          allocGrant,
  output logic [ID_W-1:0]               allocId,
  output logic                          noneFree,
  output logic [BLK_W-1:0]              blockedCount,
  output logic                          decodeErr
);

  function automatic logic inRange(input logic [ID_W-1:0] id);
    return id < ID_W'(NUM_SLOTS);
  endfunction

  function automatic logic busyAt(input logic [ID_W-1:0] id,
                                  input logic [NUM_SLOTS-1:0] b);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (id == ID_W'(i)) r = b[i];
    return r;
  endfunction

  logic            anyFree;
  logic [ID_W-1:0] pick;
  logic            freeOk, exitOk, arrOk;

  // lowest free slot wins
  always_comb begin
    anyFree = 1'b0;
    pick    = '0;
    for (int i = NUM_SLOTS-1; i >= 0; i--) begin
      if (!slotBusy[i]) begin
        anyFree = 1'b1;
        pick    = ID_W'(i);
      end
    end
  end

  assign noneFree   = !anyFree;
  assign allocGrant = allocReq && anyFree;
  assign allocId    = pick;

  always_comb begin
    freeOk = freeVld && inRange(freeId) && busyAt(freeId, slotBusy);
    exitOk = exitVld && inRange(exitId) && busyAt(exitId, slotBusy)
             && !(freeOk && (freeId == exitId));
    arrOk  = arriveVld && inRange(arriveId) && busyAt(arriveId, slotBusy)
             && !(freeOk && (freeId == arriveId));
    decodeErr = (freeVld && !freeOk) || (exitVld && !exitOk)
                || (arriveVld && !arrOk);
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_strb
    assign cmd[i].take   = allocGrant && (pick == ID_W'(i));
    assign cmd[i].drop   = freeOk && (freeId == ID_W'(i));
    assign cmd[i].leave  = exitOk && (exitId == ID_W'(i));
    assign cmd[i].arrive = arrOk && (arriveId == ID_W'(i));

    // R11
    drop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(cmd[i].drop && (cmd[i].arrive || cmd[i].leave)));
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      blockedCount <= '0;
    else if (allocReq && !anyFree && (blockedCount != '1))
      blockedCount <= blockedCount + BLK_W'(1);
  end

  // R2
  grant_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> !busyAt(allocId, slotBusy));

  // R3
  none_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    noneFree |-> !allocGrant);

  // R3
  blocked_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && noneFree && (blockedCount != '1))
      |=> (blockedCount == $past(blockedCount) + BLK_W'(1)));

endmodule

// File: rtl/wgbar_dp.sv
module wgbar_dp
  import wgbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slotCmd_t [NUM_SLOTS-1:0] cmd,
  input  logic [CNT_W-1:0]         allocCount,
  input  logic                     decodeErr,
  output logic [NUM_SLOTS-1:0]     slotBusy,
  output logic [NUM_SLOTS-1:0]     releasePulse,
  output logic                     errPulse
);

  logic [NUM_SLOTS-1:0] slotErr;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic             busyQ, relQ;
    logic [CNT_W-1:0] maxQ, arrQ, maxN, arrN;
    logic             leaveErr, arrErr, hit;

    // exit is applied before arrival
    always_comb begin
      leaveErr = cmd[i].leave && (maxQ == '0);
      maxN     = (cmd[i].leave && !leaveErr) ? maxQ - CNT_W'(1) : maxQ;
      arrErr   = cmd[i].arrive && (arrQ == maxN);
      arrN     = (cmd[i].arrive && !arrErr) ? arrQ + CNT_W'(1) : arrQ;
      hit      = ((cmd[i].leave && !leaveErr) || (cmd[i].arrive && !arrErr))
                 && (arrN == maxN) && (maxN != '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ <= 1'b0;
        maxQ  <= '0;
        arrQ  <= '0;
        relQ  <= 1'b0;
      end else if (cmd[i].drop) begin
        busyQ <= 1'b0;
        maxQ  <= '0;
        arrQ  <= '0;
        relQ  <= 1'b0;
      end else if (cmd[i].take) begin
        busyQ <= 1'b1;
        maxQ  <= allocCount;
        arrQ  <= '0;
        relQ  <= 1'b0;
      end else begin
        maxQ  <= maxN;
        arrQ  <= hit ? '0 : arrN;
        relQ  <= hit;
      end
    end

    assign slotBusy[i]     = busyQ;
    assign releasePulse[i] = relQ;
    assign slotErr[i]      = leaveErr || arrErr;

    // R4
    arr_below_max_chk: assert property (@(posedge clk) disable iff (!rstN)
      (maxQ == '0) ? (arrQ == '0) : (arrQ < maxQ));

    // R4
    rel_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
      relQ |-> (arrQ == '0) && busyQ);

    // R8
    free_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmd[i].drop |=> !busyQ && (maxQ == '0));

    // R2
    take_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmd[i].take |=> busyQ && (arrQ == '0) && (maxQ == $past(allocCount)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= decodeErr || (|slotErr);
  end

endmodule

// File: rtl/wg_barrier_pool.sv
module wg_barrier_pool
  import wgbar_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 4,
  parameter int BLK_W     = 8,
  localparam int ID_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocReq,
  input  logic [CNT_W-1:0]     allocCount,
  output logic                 allocGrant,
  output logic [ID_W-1:0]      allocId,
  output logic                 noneFree,
  input  logic                 arriveVld,
  input  logic [ID_W-1:0]      arriveId,
  input  logic                 exitVld,
  input  logic [ID_W-1:0]      exitId,
  input  logic                 freeVld,
  input  logic [ID_W-1:0]      freeId,
  output logic [NUM_SLOTS-1:0] slotBusy,
  output logic [NUM_SLOTS-1:0] releasePulse,
  output logic                 errPulse,
  output logic [BLK_W-1:0]     blockedCount
);

  slotCmd_t [NUM_SLOTS-1:0] cmd;
  logic                     decodeErr;

  wgbar_ctrl #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq),
    .arriveVld(arriveVld), .arriveId(arriveId),
    .exitVld(exitVld), .exitId(exitId),
    .freeVld(freeVld), .freeId(freeId),
    .slotBusy(slotBusy), .cmd(cmd),
    .allocGrant(allocGrant), .allocId(allocId), .noneFree(noneFree),
    .blockedCount(blockedCount), .decodeErr(decodeErr)
  );

  wgbar_dp #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .allocCount(allocCount),
    .decodeErr(decodeErr), .slotBusy(slotBusy),
    .releasePulse(releasePulse), .errPulse(errPulse)
  );

endmodule

// File: tb/wg_barrier_pool_bench.sv
`timescale 1ns/1ps
module wg_barrier_pool_bench;
  localparam int NS = 4, CW = 3, BW = 4, IW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocReq = 1'b0;
  logic [CW-1:0] allocCount = '0;
  logic allocGrant, noneFree, errPulse;
  logic [IW-1:0] allocId;
  logic arriveVld = 1'b0, exitVld = 1'b0, freeVld = 1'b0;
  logic [IW-1:0] arriveId = '0, exitId = '0, freeId = '0;
  logic [NS-1:0] slotBusy, releasePulse;
  logic [BW-1:0] blockedCount;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wg_barrier_pool #(.NUM_SLOTS(NS), .CNT_W(CW), .BLK_W(BW)) u_wg_barrier_pool (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocCount(allocCount),
    .allocGrant(allocGrant), .allocId(allocId), .noneFree(noneFree),
    .arriveVld(arriveVld), .arriveId(arriveId), .exitVld(exitVld),
    .exitId(exitId), .freeVld(freeVld), .freeId(freeId),
    .slotBusy(slotBusy), .releasePulse(releasePulse), .errPulse(errPulse),
    .blockedCount(blockedCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // apply one cycle of commands (called at a negedge), return at next negedge
  task automatic drive(input bit a, input int aid, input bit e, input int eid,
                       input bit f, input int fid);
    arriveVld = a; arriveId = IW'(aid);
    exitVld   = e; exitId   = IW'(eid);
    freeVld   = f; freeId   = IW'(fid);
    @(negedge clk);
    arriveVld = 0; exitVld = 0; freeVld = 0;
  endtask

  task automatic arrive(input int id); drive(1, id, 0, 0, 0, 0); endtask
  task automatic leave(input int id);  drive(0, 0, 1, id, 0, 0); endtask
  task automatic free(input int id);   drive(0, 0, 0, 0, 1, id); endtask

  task automatic alloc(input int cnt, input int expId, input string tag);
    allocReq = 1; allocCount = CW'(cnt);
    #1;
    check({tag, " grant"}, allocGrant, 1);
    check({tag, " id"}, allocId, expId);
    @(negedge clk);
    allocReq = 0;
    check({tag, " busy"}, slotBusy[expId], 1);
  endtask

  task automatic t_reset();
    check("R1 busy", slotBusy, 0);
    check("R1 release", releasePulse, 0);
    check("R1 err", errPulse, 0);
    check("R1 blocked", blockedCount, 0);
    check("R1 noneFree", noneFree, 0);
  endtask

  task automatic t_alloc();
    alloc(3, 0, "R2 a0");
    alloc(2, 1, "R2 a1");
    alloc(1, 2, "R2 a2");
    check("R2 busy map", slotBusy, 4'b0111);
    check("R2 no err", errPulse, 0);
  endtask

  task automatic t_barrier();
    arrive(0); check("R4 first", releasePulse, 0);
    arrive(0); check("R4 second", releasePulse, 0);
    arrive(0); check("R4 last releases", releasePulse, 4'b0001);
    check("R4 no err", errPulse, 0);
    @(negedge clk); check("R4 one cycle", releasePulse, 0);
    arrive(0); arrive(0); check("R4 restart count", releasePulse, 0);
    arrive(0); check("R4 second instance", releasePulse, 4'b0001);
  endtask

  task automatic t_exit();
    arrive(1); check("R6 pending", releasePulse, 0);
    leave(1);  check("R6 exit completes", releasePulse, 4'b0010);
    check("R6 exit ok", errPulse, 0);
    arrive(1); check("R6 lowered count", releasePulse, 4'b0010);
    leave(1);  check("R6 to zero", releasePulse, 0);
    check("R6 to zero ok", errPulse, 0);
    leave(1);  check("R6 exit on zero", errPulse, 1);
  endtask

  task automatic t_zero();
    arrive(1); check("R5 arrive on zero err", errPulse, 1);
    check("R5 no release", releasePulse, 0);
  endtask

  task automatic t_order();
    arrive(0);
    drive(1, 0, 1, 0, 0, 0);
    check("R7 exit+arrive release", releasePulse, 4'b0001);
    check("R7 exit+arrive no err", errPulse, 0);
    arrive(0);
    drive(1, 0, 1, 0, 0, 0);
    check("R7 exit first release", releasePulse, 4'b0001);
    check("R7 late arrive err", errPulse, 1);
    arrive(0);
    check("R7 count is one", releasePulse, 4'b0001);
  endtask

  task automatic t_invalid();
    arrive(7); check("R9 invalid arrive err", errPulse, 1);
    check("R9 invalid no rel", releasePulse, 0);
    arrive(5); check("R9 range arrive err", errPulse, 1);
    leave(7);  check("R9 invalid exit err", errPulse, 1);
    free(7);   check("R9 invalid free err", errPulse, 1);
    check("R9 busy kept", slotBusy, 4'b0111);
    arrive(2); check("R9 count intact", releasePulse, 4'b0100);
  endtask

  task automatic t_parallel();
    alloc(2, 3, "R10 a3");
    arrive(3);
    drive(1, 0, 1, 3, 0, 0);
    check("R10 two releases", releasePulse, 4'b1001);
    check("R10 no err", errPulse, 0);
  endtask

  task automatic t_full();
    allocReq = 1; allocCount = 1;
    #1;
    check("R3 noneFree", noneFree, 1);
    check("R3 no grant", allocGrant, 0);
    @(negedge clk);
    check("R3 blocked one", blockedCount, 1);
    for (int i = 0; i < 19; i++) @(negedge clk);
    allocReq = 0;
    check("R3 saturate", blockedCount, 15);
    check("R3 busy kept", slotBusy, 4'b1111);
  endtask

  task automatic t_free();
    free(1);   check("R8 freed", slotBusy, 4'b1101);
    check("R8 free ok", errPulse, 0);
    check("R8 noneFree low", noneFree, 0);
    free(1);   check("R8 free idle err", errPulse, 1);
    arrive(1); check("R8 arrive idle err", errPulse, 1);
    alloc(2, 1, "R8 realloc");
    drive(1, 0, 0, 0, 1, 0);
    check("R11 free wins err", errPulse, 1);
    check("R11 no release", releasePulse, 0);
    check("R11 slot freed", slotBusy, 4'b1110);
    free(2);
    alloc(1, 0, "R2 lowest after free");
  endtask

  initial begin
    #400000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_barrier();
    t_exit();
    t_zero();
    t_order();
    t_invalid();
    t_parallel();
    t_full();
    t_free();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule